// File: doc/BRIEF.md
# Two-Wire Four-Phase TAP Bridge

This block lets a host-side controller run ordinary JTAG test-access-port traffic over a programming link that has only two wires: a clock driven by the bridge and one shared data line. Each TAP clock is spread over four link clock periods. The bridge drives TDI in the first period and TMS in the second. It then releases the data line for two periods, and the target returns TDO during the fourth period. The link clock rate comes from a divider parameter.

The host issues one request at a time. A request is a kind code, a length, and two bit vectors. A raw request shifts up to `SLOTS` arbitrary (TDI, TMS) pairs. A mode-set request shifts the fixed six-slot TMS pattern with TDI held low. A shift request wraps a data word in the standard header and footer pairs. When the request is finished, the bridge raises a one-cycle done strobe. At the same time it presents the captured TDO bits, least significant first, together with how many of them are valid.

Top module: `twowire_tap_bridge`

## Requirements
- R1: After reset, busy and done are 0, the link clock is low, the data line is driven (oe=1), and the driven value is 0.
- R2: Each TAP slot takes four link clock periods of 2*HALF cycles each: high for HALF cycles, then low for HALF cycles. The data line is driven (oe=1) in periods 1 and 2 and released (oe=0) in periods 3 and 4. A request of n slots therefore keeps busy high for exactly 8*HALF*n cycles.
- R3: The value on the data line changes only together with a rising link clock, so it is stable across every falling link clock edge. Period 1 of slot k carries that slot's TDI and period 2 carries its TMS.
- R4: Kind code 2'b00 is a raw request; code 2'b11 is treated the same way. Slot k carries TDI=cmd_tdi[k] and TMS=cmd_tms[k]. The slot count is cmd_len, limited to SLOTS.
- R5: Kind code 2'b01 is mode-set. It sends six slots with TDI=0 and TMS, in send order, 0,1,1,1,1,1. cmd_len, cmd_tdi and cmd_tms are ignored.
- R6: Kind code 2'b10 is a shift of N=min(cmd_len, SLOTS-6) data bits, sent in this order:
  - header slots with (TDI,TMS) = (0,1),(0,1),(0,0),(0,0);
  - N data slots carrying cmd_tdi[0..N-1], with TMS=0 except TMS=1 on the last (most significant) one;
  - footer slots (0,1),(0,0).
  This gives N+6 slots in total. cmd_tms is ignored.
- R7: TDO is sampled while the link clock is high in period 4 of each slot. For raw and mode-set requests, rsp_tdo[k] is the TDO of slot k. Bits at and above the slot count read 0.
- R8: For a shift, rsp_tdo[k] is the TDO of slot 3+k for k<N, so the last header slot gives bit 0. rsp_count is N, and higher bits read 0.
- R9: done is a single-cycle pulse in the first cycle busy is low after a request. rsp_count holds the number of valid TDO bits.
- R10: A request whose slot count is 0 (raw length 0, or shift length 0) raises done in the cycle after acceptance with rsp_count=0. busy stays low and the link clock does not toggle.
- R11: A request is accepted when cmd_valid is high while busy is low. busy then rises in the next cycle and stays high until the last slot ends. cmd_valid while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_valid | input | 1 | request strobe, taken when busy is low |
| cmd_kind | input | 2 | 00 raw, 01 mode-set, 10 shift, 11 raw |
| cmd_len | input | $clog2(SLOTS+1) | slot count (raw) or data bit count (shift) |
| cmd_tdi | input | SLOTS | TDI per slot (raw) or data word (shift), bit 0 first |
| cmd_tms | input | SLOTS | TMS per slot for raw requests |
| busy | output | 1 | request in progress |
| done | output | 1 | one-cycle completion strobe |
| rsp_tdo | output | SLOTS | captured TDO bits, LSB first |
| rsp_count | output | $clog2(SLOTS+1) | number of valid bits in rsp_tdo |
| link_clk | output | 1 | link clock to the target |
| link_dat_out | output | 1 | value driven on the data line |
| link_dat_oe | output | 1 | data line output enable |
| link_dat_in | input | 1 | value read from the data line |

## Verification
The bench builds the bridge with SLOTS=64 and HALF=2. Two-cycle half periods make the timing check meaningful: a single-cycle half period would hide a sample or a data change placed in the wrong cycle of a phase. A slot count of 64 puts the full raw length range of 0 to 64 within reach, along with every shift length from 0 to 58. Clamping above both limits is reachable too, so each sweep step compares the observed pin pairs, the TDO bits and the busy time with arithmetic predictions.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    KIND_RAW   = 2'b00,
    KIND_MODE  = 2'b01,
    KIND_SHIFT = 2'b10
  } tw_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tw_state_e;
endpackage

// File: rtl/tw_seq_build.sv
module tw_seq_build
  import tw_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  tw_kind_e         kind,
  input  logic [CW-1:0]    len,
  input  logic [SLOTS-1:0] tdi,
  input  logic [SLOTS-1:0] tms,
  output logic [SLOTS-1:0] seq_tdi,
  output logic [SLOTS-1:0] seq_tms,
  output logic [CW-1:0]    nslots,
  output logic [1:0]       skip,
  output logic [CW-1:0]    caplen
);
  localparam int IW   = $clog2(SLOTS);
  localparam int MAXD = SLOTS - 6;

  always_comb begin
    int n_data;
    int n_raw;
    seq_tdi = '0;
    seq_tms = '0;
    nslots  = '0;
    skip    = 2'd0;
    caplen  = '0;
    n_data  = (int'(len) > MAXD) ? MAXD : int'(len);
    n_raw   = (int'(len) > SLOTS) ? SLOTS : int'(len);
    case (kind)
      KIND_MODE: begin
        for (int i = 1; i < 6; i++) seq_tms[IW'(i)] = 1'b1;
        nslots = CW'(6);
        caplen = CW'(6);
      end
      KIND_SHIFT: begin
        if (n_data > 0) begin
          for (int i = 0; i < SLOTS; i++) begin
            if (i < 2) begin
              seq_tms[IW'(i)] = 1'b1;
            end else if (i >= 4 && i < 4 + n_data) begin
              seq_tdi[IW'(i)] = tdi[IW'(i - 4)];
              seq_tms[IW'(i)] = (i == 3 + n_data);
            end else if (i == 4 + n_data) begin
              seq_tms[IW'(i)] = 1'b1;
            end
          end
          nslots = CW'(n_data + 6);
          skip   = 2'd3;
          caplen = CW'(n_data);
        end
      end
      default: begin
        seq_tdi = tdi;
        seq_tms = tms;
        nslots  = CW'(n_raw);
        caplen  = CW'(n_raw);
      end
    endcase
  end
endmodule

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic [$clog2(2*HALF)-1:0] tick,
  output logic [1:0] phase,
  output logic       slot_end,
  output logic       sample
);
  localparam int TW   = $clog2(2 * HALF);
  localparam int LAST = 2 * HALF - 1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tick  <= '0;
      phase <= 2'd0;
    end else if (tick == TW'(LAST)) begin
      tick  <= '0;
      phase <= phase + 2'd1;
    end else begin
      tick <= tick + TW'(1);
    end
  end

  assign slot_end = run && (phase == 2'd3) && (tick == TW'(LAST));
  assign sample   = run && (phase == 2'd3) && (tick == TW'(HALF));

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(rst) && $past(tick) == TW'(LAST)) |-> (tick == '0));
endmodule

// File: rtl/tw_tdo_capture.sv
module tw_tdo_capture #(
  parameter int SLOTS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     we,
  input  logic [$clog2(SLOTS)-1:0] idx,
  input  logic                     din,
  output logic [SLOTS-1:0]         bits
);
  always_ff @(posedge clk) begin
    if (rst || clear) bits <= '0;
    else if (we)      bits[idx] <= din;
  end
endmodule

// File: rtl/twowire_tap_bridge.sv
module twowire_tap_bridge
  import tw_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int HALF  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_kind,
  input  logic [$clog2(SLOTS+1)-1:0]   cmd_len,
  input  logic [SLOTS-1:0]             cmd_tdi,
  input  logic [SLOTS-1:0]             cmd_tms,
  output logic                         busy,
  output logic                         done,
  output logic [SLOTS-1:0]             rsp_tdo,
  output logic [$clog2(SLOTS+1)-1:0]   rsp_count,
  output logic                         link_clk,
  output logic                         link_dat_out,
  output logic                         link_dat_oe,
  input  logic                         link_dat_in
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int IW = $clog2(SLOTS);
  localparam int TW = $clog2(2 * HALF);

  tw_state_e        state_q;
  logic [SLOTS-1:0] seq_tdi_q, seq_tms_q, b_tdi, b_tms;
  logic [CW-1:0]    nslots_q, caplen_q, slot_q, b_nslots, b_caplen;
  logic [1:0]       skip_q, b_skip;
  logic [TW-1:0]    tick;
  logic [1:0]       phase;
  logic             slot_end, sample, accept, run, cap_we;
  logic             clk_q, out_q, oe_q, done_q;
  logic [CW-1:0]    count_q;

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);

  tw_seq_build #(.SLOTS(SLOTS), .CW(CW)) u_build (
    .kind(tw_kind_e'(cmd_kind)), .len(cmd_len), .tdi(cmd_tdi), .tms(cmd_tms),
    .seq_tdi(b_tdi), .seq_tms(b_tms), .nslots(b_nslots), .skip(b_skip),
    .caplen(b_caplen)
  );

  tw_phase_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .phase(phase),
    .slot_end(slot_end), .sample(sample)
  );

  assign cap_we = sample && (slot_q >= CW'(skip_q)) &&
                  ((slot_q - CW'(skip_q)) < caplen_q);

  tw_tdo_capture #(.SLOTS(SLOTS)) u_cap (
    .clk(clk), .rst(rst), .clear(accept), .we(cap_we),
    .idx(IW'(slot_q - CW'(skip_q))), .din(link_dat_in), .bits(rsp_tdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      seq_tdi_q <= '0;
      seq_tms_q <= '0;
      nslots_q  <= '0;
      caplen_q  <= '0;
      skip_q    <= 2'd0;
      slot_q    <= '0;
      done_q    <= 1'b0;
      count_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        seq_tdi_q <= b_tdi;
        seq_tms_q <= b_tms;
        nslots_q  <= b_nslots;
        caplen_q  <= b_caplen;
        skip_q    <= b_skip;
        slot_q    <= '0;
        if (b_nslots == '0) begin
          done_q  <= 1'b1;
          count_q <= '0;
        end else begin
          state_q <= ST_RUN;
        end
      end else if (run && slot_end) begin
        if (slot_q == nslots_q - CW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          count_q <= caplen_q;
        end else begin
          slot_q <= slot_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      clk_q <= 1'b0;
      out_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      clk_q <= (tick < TW'(HALF));
      oe_q  <= (phase < 2'd2);
      case (phase)
        2'd0:    out_q <= seq_tdi_q[IW'(slot_q)];
        2'd1:    out_q <= seq_tms_q[IW'(slot_q)];
        default: out_q <= 1'b0;
      endcase
    end
  end

  assign busy         = run;
  assign done         = done_q;
  assign rsp_count    = count_q;
  assign link_clk     = clk_q;
  assign link_dat_out = out_q;
  assign link_dat_oe  = oe_q;

  // R3
  fall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_q) |-> $stable(out_q));
  // R2
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (run && phase >= 2'd2) |=> !oe_q);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !run);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> done_q);
  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && b_nslots == '0) |=> (done_q && !run));
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($stable(nslots_q) && $stable(seq_tms_q)));
endmodule

// File: tb/twowire_tap_bridge_test.sv
module twowire_tap_bridge_test;
  localparam int SLOTS = 64;
  localparam int HALF  = 2;
  localparam int CW    = $clog2(SLOTS + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [CW-1:0] cmd_len = '0;
  logic [SLOTS-1:0] cmd_tdi = '0, cmd_tms = '0;
  logic busy, done, link_clk, link_dat_out, link_dat_oe;
  logic link_dat_in = 1'b0;
  logic [SLOTS-1:0] rsp_tdo;
  logic [CW-1:0] rsp_count;

  int checks = 0, errors = 0, cyc = 0;

  twowire_tap_bridge #(.SLOTS(SLOTS), .HALF(HALF)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_len(cmd_len), .cmd_tdi(cmd_tdi), .cmd_tms(cmd_tms), .busy(busy),
    .done(done), .rsp_tdo(rsp_tdo), .rsp_count(rsp_count),
    .link_clk(link_clk), .link_dat_out(link_dat_out),
    .link_dat_oe(link_dat_oe), .link_dat_in(link_dat_in)
  );

  always #4 clk = ~clk;

  // target model on the link
  logic [63:0] pat = '0, seen_tdi = '0, seen_tms = '0;
  int rise_cnt = 0, cur_ph = 0, cur_sl = 0, oe_err = 0;

  always @(posedge link_clk) begin
    cur_ph = rise_cnt % 4;
    cur_sl = rise_cnt / 4;
    if (cur_ph == 2 && cur_sl < 64) link_dat_in = pat[cur_sl];
    rise_cnt++;
  end

  always @(negedge link_clk) begin
    if (cur_sl < 64) begin
      if (cur_ph == 0) seen_tdi[cur_sl] = link_dat_out;
      if (cur_ph == 1) seen_tms[cur_sl] = link_dat_out;
    end
    if (link_dat_oe !== (cur_ph < 2)) oe_err++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R9 run did not end got=%0d exp=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] mask(input int n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] mix(input int s);
    logic [31:0] a;
    logic [31:0] b;
    a = 32'(s + 1) * 32'h9E3779B1;
    b = ~(32'(s + 7) * 32'h85EBCA6B);
    return {a ^ (b >> 5), b ^ (a << 3)};
  endfunction

  int got_k, busy_cnt;
  logic [63:0] got_tdo;
  int got_cnt;

  task automatic run_cmd(input logic [1:0] kind, input int len,
                         input logic [63:0] tdi, input logic [63:0] tms,
                         input logic [63:0] pt, input bit intrude);
    int k;
    pat = pt; rise_cnt = 0; seen_tdi = '0; seen_tms = '0; oe_err = 0;
    busy_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_len = CW'(len);
    cmd_tdi = tdi; cmd_tms = tms;
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 1;
    forever begin
      if (done) break;
      if (busy) busy_cnt++;
      if (intrude && k == 20) begin
        cmd_valid = 1'b1; cmd_kind = 2'b01; cmd_len = CW'(6);
        cmd_tdi = '1; cmd_tms = '0;
      end
      if (k == 21) cmd_valid = 1'b0;
      @(negedge clk);
      k++;
      if (k > 5000) break;
    end
    got_k = k; got_tdo = rsp_tdo; got_cnt = int'(rsp_count);
    chk("R9", "busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R9", "done single cycle", 64'(done), 64'd0);
  endtask

  // checks common to all requests of n slots
  task automatic check_frame(input string req, input int n,
                             input logic [63:0] etdi, input logic [63:0] etms,
                             input logic [63:0] etdo, input int ecnt);
    chk(req, "tdi pairs", seen_tdi, etdi);
    chk(req, "tms pairs", seen_tms, etms);
    chk(req == "R8" ? "R8" : "R7", "tdo bits", got_tdo, etdo);
    chk("R9", "count", 64'(got_cnt), 64'(ecnt));
    chk("R2", "clock rises", 64'(rise_cnt), 64'(4 * n));
    chk("R11", "busy cycles", 64'(busy_cnt), 64'(8 * HALF * n));
    chk("R2", "done latency", 64'(got_k), n == 0 ? 64'd1 : 64'(8 * HALF * n + 1));
    chk("R2", "oe per phase", 64'(oe_err), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "clk", 64'(link_clk), 64'd0);
    chk("R1", "oe", 64'(link_dat_oe), 64'd1);
    chk("R1", "out", 64'(link_dat_out), 64'd0);

    // R4 raw sweep, every length, R10 at length 0
    for (int len = 0; len <= 64; len++) begin
      logic [63:0] ti, tm, pt;
      ti = mix(len); tm = mix(len + 100); pt = mix(len + 200);
      run_cmd(2'b00, len, ti, tm, pt, 1'b0);
      check_frame("R4", len, ti & mask(len), tm & mask(len), pt & mask(len), len);
    end
    // R4 clamp above the limit, and code 2'b11 as raw
    run_cmd(2'b00, 100, mix(1), mix(2), mix(3), 1'b0);
    check_frame("R4", 64, mix(1), mix(2), mix(3), 64);
    run_cmd(2'b11, 5, mix(4), mix(5), mix(6), 1'b0);
    check_frame("R4", 5, mix(4) & mask(5), mix(5) & mask(5), mix(6) & mask(5), 5);

    // R5 mode-set, inputs ignored
    run_cmd(2'b01, 0, '1, '1, mix(7), 1'b0);
    check_frame("R5", 6, 64'd0, 64'h3E, mix(7) & mask(6), 6);
    run_cmd(2'b01, 33, '0, '0, 64'h2A, 1'b0);
    check_frame("R5", 6, 64'd0, 64'h3E, 64'h2A, 6);

    // R6 / R8 shift sweep with clamp, R10 at length 0
    for (int len = 0; len <= 60; len++) begin
      int nd, n;
      logic [63:0] d, ex_tms, ex_tdi;
      nd = (len > 58) ? 58 : len;
      n  = (nd == 0) ? 0 : nd + 6;
      d  = mix(len + 300);
      if (nd == 0) begin
        ex_tms = '0; ex_tdi = '0;
      end else begin
        ex_tms = 64'h3 | (64'd1 << (3 + nd)) | (64'd1 << (4 + nd));
        ex_tdi = (d & mask(nd)) << 4;
      end
      run_cmd(2'b10, len, d, mix(len + 400), mix(len + 500), 1'b0);
      check_frame("R6", n, ex_tdi, ex_tms, (mix(len + 500) >> 3) & mask(nd), nd);
      if (nd > 0) chk("R8", "header last slot is bit0", 64'(got_tdo[0]),
                      64'(mix(len + 500) >> 3) & 64'd1);
    end

    // R11 request while busy is ignored
    run_cmd(2'b00, 12, mix(8), mix(9), mix(10), 1'b1);
    check_frame("R11", 12, mix(8) & mask(12), mix(9) & mask(12), mix(10) & mask(12), 12);
    // R10 no clock after the ignored request
    repeat (40) @(negedge clk);
    chk("R11", "no late start", 64'(busy), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule